// File: doc/BRIEF.md
# UART Register Block with Receive FIFO

This block is the software-facing register set of a serial port. It sits on a 32-bit bus addressed in words. Bytes that the receiver has assembled come in through a valid/ready byte input and are stored in a receive FIFO that software drains by reading the data word. A write to the data word produces a one-cycle strobe carrying the byte to the transmitter. The serial shifter, the baud generator and DMA are outside the block. The divisor, line, control, FIFO-level and DMA words are only stored here and read back for the logic that uses them.

A flag word reports FIFO state. A raw interrupt word, a mask, a masked view and a write-one-to-clear word drive a single registered interrupt line. The last eight words of the 4 KB window return a fixed identification byte sequence. Line-control bit 4 sets the receive capacity: 16 bytes when it is set, 1 byte when it is clear.

Top module: `uart_regs`

## Requirements
- R1: After reset the following hold: flags (word 6) read 0x90, control (word 12) reads 0x300, FIFO-level select (word 13) reads 0x12, and line control, raw status and masked status read 0. irq and tx_strobe are 0 and rx_ready is 1.
- R2: Each storage word keeps the low bits of the last value written to it and reads them back, with the upper bits reading 0:
  - word 8: low-power divisor, 8 bits
  - word 9: integer divisor, 16 bits
  - word 10: fractional divisor, 6 bits
  - word 11: line control, 8 bits
  - word 12: control, 16 bits
  - word 13: FIFO-level select, 6 bits
  - word 18: DMA control, 3 bits
- R3: A byte is accepted when rx_valid and rx_ready are both high at a clock edge. A read of word 0 returns the oldest stored byte in bits 7:0 and removes it. The read and write pointers wrap modulo 16.
- R4: The receive capacity is 16 when line-control bit 4 is 1 and 1 when it is 0. rx_ready is low exactly when the stored count equals the capacity, and a byte offered while rx_ready is low is dropped.
- R5: The flag word has these bits:
  - bit 7 (transmit empty) always reads 1
  - bit 5 (transmit full) always reads 0
  - bit 6 (receive full) is 1 when the count equals the capacity
  - bit 4 (receive empty) is 1 when the count is 0
- R6: Raw status bit 4 (receive) sets when the count goes from 0 to 1. It clears when a data read brings the count from 1 to 0. A push and a pop in the same cycle leave both the count and this bit unchanged.
- R7: A write to word 0 makes tx_strobe high for exactly one cycle, on the cycle after the write, with tx_data equal to wdata[7:0]. The same write sets raw status bit 5 (transmit).
- R8: A write to word 17 clears every raw status bit whose wdata bit is 1 and leaves the other raw status bits unchanged.
- R9: The mask is word 14, 11 bits wide. Masked status (word 16) reads raw status AND mask. irq equals the OR of the masked status bits, delayed by one clock.
- R10: Word addresses 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) return, in order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: A data read while the FIFO is empty returns the byte in the slot at the read pointer. The count stays 0 and the flags stay at 0x90.
- R12: Writes to words 6, 15 and 16 change nothing, and neither do writes to unmapped words. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe; a data-word read pops at the clock edge |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is offered |
| rx_ready | output | 1 | FIFO has room under the current capacity |
| tx_data | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle pulse qualifying tx_data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with DEPTH 16 and AW 10, the values the bus map assumes. With these values, sixteen pushes and sixteen pops carry both pointers through a complete wrap. The empty read that follows then shows which slot the read pointer has come back to. The 10-bit address reaches the identification words at the top of the window, and switching line-control bit 4 exercises both the 16-entry capacity and the 1-entry capacity.

// File: rtl/uart_regs.sv
module uart_regs #(
  parameter int DEPTH = 16,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_strobe,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] W_DATA = AW'(0),  W_FLAG = AW'(6),  W_LPD = AW'(8),
                            W_IDIV = AW'(9),  W_FDIV = AW'(10), W_LINE = AW'(11),
                            W_CTRL = AW'(12), W_LVL = AW'(13),  W_MASK = AW'(14),
                            W_RAW = AW'(15),  W_MIS = AW'(16),  W_CLR = AW'(17),
                            W_DMA = AW'(18);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic [7:0]    lp_div, line;
  logic [15:0]   i_div, ctrl;
  logic [5:0]    f_div, lvl;
  logic [2:0]    dma;
  logic [10:0]   msk;
  logic          rx_ris, tx_ris;

  wire [CW-1:0] cap    = line[4] ? CW'(DEPTH) : CW'(1);
  wire          push   = rx_valid && rx_ready;
  wire          pop    = rd_en && addr == W_DATA && cnt != '0;
  wire [10:0]   raw_st = {5'b0, tx_ris, rx_ris, 4'b0};
  wire [10:0]   mis    = raw_st & msk;
  wire [7:0]    flags  = {1'b1, cnt == cap, 1'b0, cnt == '0, 4'b0};
  wire          id_hit = &addr[AW-1:3];
  wire          unused_ok = &{1'b0, wdata[31:16]};

  assign rx_ready = cnt < cap;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    rdata = '0;
    if (id_hit) rdata = {24'b0, id_byte(addr[2:0])};
    else
      case (addr)
        W_DATA: rdata = {24'b0, mem[rp]};
        W_FLAG: rdata = {24'b0, flags};
        W_LPD:  rdata = {24'b0, lp_div};
        W_IDIV: rdata = {16'b0, i_div};
        W_FDIV: rdata = {26'b0, f_div};
        W_LINE: rdata = {24'b0, line};
        W_CTRL: rdata = {16'b0, ctrl};
        W_LVL:  rdata = {26'b0, lvl};
        W_MASK: rdata = {21'b0, msk};
        W_RAW:  rdata = {21'b0, raw_st};
        W_MIS:  rdata = {21'b0, mis};
        W_DMA:  rdata = {29'b0, dma};
        default: rdata = '0;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rp <= '0;
      wp <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= rx_data;
        wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lp_div <= '0; i_div <= '0; f_div <= '0; line <= '0;
      ctrl <= 16'h0300; lvl <= 6'h12; dma <= '0; msk <= '0;
    end else if (wr_en) begin
      case (addr)
        W_LPD:  lp_div <= wdata[7:0];
        W_IDIV: i_div  <= wdata[15:0];
        W_FDIV: f_div  <= wdata[5:0];
        W_LINE: line   <= wdata[7:0];
        W_CTRL: ctrl   <= wdata[15:0];
        W_LVL:  lvl    <= wdata[5:0];
        W_MASK: msk    <= wdata[10:0];
        W_DMA:  dma    <= wdata[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ris <= 1'b0;
      tx_ris <= 1'b0;
      tx_strobe <= 1'b0;
      tx_data <= '0;
      irq <= 1'b0;
    end else begin
      if (push && !pop && cnt == '0) rx_ris <= 1'b1;
      else if (pop && !push && cnt == CW'(1)) rx_ris <= 1'b0;
      else if (wr_en && addr == W_CLR && wdata[4]) rx_ris <= 1'b0;

      if (wr_en && addr == W_DATA) tx_ris <= 1'b1;
      else if (wr_en && addr == W_CLR && wdata[5]) tx_ris <= 1'b0;

      tx_strobe <= wr_en && addr == W_DATA;
      if (wr_en && addr == W_DATA) tx_data <= wdata[7:0];
      irq <= |mis;
    end
  end
endmodule

// File: rtl/uart_regs_chk.sv
module uart_regs_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 10,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_strobe,
  input logic          irq,
  input logic [CW-1:0] cnt,
  input logic [10:0]   raw_st,
  input logic [10:0]   msk
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !(rd_en && addr == '0)) |=> cnt == $past(cnt)); // R4
  AST_RX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && rx_valid && rx_ready && !(rd_en && addr == '0)) |=> raw_st[4]); // R6
  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe == $past(wr_en && addr == '0)); // R7
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(raw_st & msk))); // R9
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !rx_valid) |=> cnt == '0); // R11
endmodule

bind uart_regs uart_regs_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_strobe(tx_strobe), .irq(irq),
  .cnt(cnt), .raw_st(raw_st), .msk(msk)
);

// File: tb/uart_regs_test.sv
module uart_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_strobe, irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  uart_regs #(.DEPTH(16), .AW(10)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_strobe(tx_strobe), .irq(irq)
  );

  // {op: 0 write / 1 read-check, word address, data, requirement}
  localparam int NV = 37;
  localparam logic [63:0] VEC [NV] = '{
    {8'd1, 16'h006, 32'h90,  8'd1}, {8'd1, 16'h00C, 32'h300, 8'd1},   // R1
    {8'd1, 16'h00D, 32'h12,  8'd1}, {8'd1, 16'h00B, 32'h0,   8'd1},
    {8'd1, 16'h00F, 32'h0,   8'd1}, {8'd1, 16'h010, 32'h0,   8'd1},
    {8'd0, 16'h008, 32'hFFFFFFA5, 8'd2}, {8'd1, 16'h008, 32'hA5, 8'd2}, // R2
    {8'd0, 16'h009, 32'h00012345, 8'd2}, {8'd1, 16'h009, 32'h2345, 8'd2},
    {8'd0, 16'h00A, 32'hFF,  8'd2}, {8'd1, 16'h00A, 32'h3F,  8'd2},
    {8'd0, 16'h00C, 32'h000ABCDE, 8'd2}, {8'd1, 16'h00C, 32'hBCDE, 8'd2},
    {8'd0, 16'h00D, 32'h7F,  8'd2}, {8'd1, 16'h00D, 32'h3F,  8'd2},
    {8'd0, 16'h012, 32'hF,   8'd2}, {8'd1, 16'h012, 32'h7,   8'd2},
    {8'd0, 16'h00B, 32'h70,  8'd2}, {8'd1, 16'h00B, 32'h70,  8'd2},
    {8'd0, 16'h00E, 32'hFFF, 8'd9}, {8'd1, 16'h00E, 32'h7FF, 8'd9},   // R9
    {8'd0, 16'h006, 32'h0,   8'd12}, {8'd1, 16'h006, 32'h90, 8'd12},  // R12
    {8'd0, 16'h00F, 32'h30,  8'd12}, {8'd1, 16'h00F, 32'h0,  8'd12},
    {8'd0, 16'h100, 32'h55,  8'd12}, {8'd1, 16'h100, 32'h0,  8'd12},
    {8'd1, 16'h3F8, 32'h11,  8'd10}, {8'd1, 16'h3F9, 32'h10, 8'd10},  // R10
    {8'd1, 16'h3FA, 32'h14,  8'd10}, {8'd1, 16'h3FB, 32'h00, 8'd10},
    {8'd1, 16'h3FC, 32'h0D,  8'd10}, {8'd1, 16'h3FD, 32'hF0, 8'd10},
    {8'd1, 16'h3FE, 32'h05,  8'd10}, {8'd1, 16'h3FF, 32'hB1, 8'd10},
    {8'd1, 16'h010, 32'h0,   8'd12}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, output logic rdy);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    #1 rdy = rx_ready;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic rdy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", irq, 0);
    check("R1 tx_strobe", tx_strobe, 0);
    check("R1 rx_ready", rx_ready, 1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][63:56] == 8'd0) bus_wr(VEC[i][49:40], VEC[i][39:8]);
      else begin
        bus_rd(VEC[i][49:40], d);
        check($sformatf("R%0d table %0d", VEC[i][7:0], i), d, VEC[i][39:8]);
      end
    end

    // R3 R4 R5 R6: FIFO mode, fill to 16
    for (int i = 0; i < 16; i++) begin
      push(8'hA0 + 8'(i), rdy);
      check("R4 ready while filling", rdy, 1);
      if (i == 0) begin
        bus_rd(10'd15, d); check("R6 rx raw set", d, 32'h10);
        @(negedge clk); check("R9 irq", irq, 1);
        bus_rd(10'd16, d); check("R9 masked", d, 32'h10);
      end
    end
    bus_rd(10'd6, d); check("R5 flags full", d, 32'hC0);
    check("R4 ready low at 16", rx_ready, 0);
    push(8'hEE, rdy);
    check("R4 ready low on offer", rdy, 0);
    for (int i = 0; i < 16; i++) begin
      bus_rd(10'd0, d); check("R3 pop order", d, 32'hA0 + i);
    end
    bus_rd(10'd6, d); check("R5 flags empty", d, 32'h90);
    bus_rd(10'd15, d); check("R6 rx raw cleared", d, 32'h0);
    // R11: after wrap the read pointer is back at slot 0
    bus_rd(10'd0, d); check("R11 empty read", d, 32'hA0);
    bus_rd(10'd6, d); check("R11 flags stay", d, 32'h90);

    // R6: simultaneous push and pop
    push(8'h11, rdy);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h22; rd_en = 1'b1; addr = 10'd0;
    #1 d = rdata;
    @(negedge clk); rx_valid = 1'b0; rd_en = 1'b0;
    check("R6 pop during push", d, 32'h11);
    bus_rd(10'd15, d); check("R6 raw kept", d, 32'h10);
    bus_rd(10'd0, d); check("R3 second byte", d, 32'h22);
    bus_rd(10'd15, d); check("R6 raw after drain", d, 32'h0);

    // R4: single-byte mode
    bus_wr(10'd11, 32'h0);
    push(8'h33, rdy); check("R4 first accepted", rdy, 1);
    check("R4 ready low at 1", rx_ready, 0);
    bus_rd(10'd6, d); check("R5 full in 1-byte mode", d, 32'hC0);
    push(8'h44, rdy); check("R4 second refused", rdy, 0);
    bus_rd(10'd0, d); check("R4 held byte", d, 32'h33);
    bus_rd(10'd6, d); check("R4 empty again", d, 32'h90);

    // R7 transmit strobe, R8 clear, R9 mask
    bus_wr(10'd0, 32'h1C5);
    check("R7 strobe high", tx_strobe, 1);
    check("R7 tx byte", tx_data, 32'hC5);
    @(negedge clk); check("R7 strobe one cycle", tx_strobe, 0);
    bus_rd(10'd15, d); check("R7 tx raw", d, 32'h20);
    check("R9 irq on tx", irq, 1);
    bus_wr(10'd17, 32'h10);
    bus_rd(10'd15, d); check("R8 other bit kept", d, 32'h20);
    bus_wr(10'd17, 32'h20);
    bus_rd(10'd15, d); check("R8 cleared", d, 32'h0);
    check("R9 irq low", irq, 0);
    bus_wr(10'd14, 32'h10);
    bus_wr(10'd0, 32'h7);
    bus_rd(10'd16, d); check("R9 masked off", d, 32'h0);
    @(negedge clk); check("R9 irq masked", irq, 0);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_rd(10'd15, d); check("R1 raw after reset", d, 32'h0);
    bus_rd(10'd12, d); check("R1 control after reset", d, 32'h300);
    bus_rd(10'd11, d); check("R1 line after reset", d, 32'h0);
    finish_run();
  end
endmodule